// File: doc/BRIEF.md
# Dual-Channel Edge Capture with Shared FIFO Watermark

This block timestamps transitions of one asynchronous secondary input. The input is synchronized, and its rising and falling transitions are detected. Two capture channels watch that same signal. Each channel has its own edge selection. When a channel's selected transition occurs, it writes the current value of an external free-running counter into its own small FIFO.

Each channel raises a capture flag while its FIFO holds more words than a watermark, and both channels share that watermark. Software, or a downstream engine, reads a FIFO by pulsing that channel's pop strobe. The oldest word is always presented on the channel's data output. When a capture arrives at a full FIFO, the word is lost and the channel's sticky overflow indicator is set.

Top module: `dual_edge_capture`

## Requirements
- R1: After reset both fill counts are 0, both flags are 0 and both overflow indicators are 0.
- R2: Each channel's 2-bit mode selects its capture events on the shared input: 2'b00 captures nothing, 2'b01 falling transitions, 2'b10 rising transitions, 2'b11 both. The two channels decode their modes independently.
- R3: A level change on `sec_in` passes through a two-flop synchronizer. The value stored is `cnt_val` at the third rising clock edge after the change.
- R4: Each FIFO is first-in first-out. While its fill is non-zero, the data output shows the oldest word. A pop strobe removes that word, and the data output then shows the next word.
- R5: Each FIFO holds 2 words. A capture at a full FIFO with no pop in the same cycle is discarded and leaves the stored words unchanged. It sets that channel's overflow indicator, which stays set until reset.
- R6: A pop strobe while the FIFO is empty has no effect: the fill stays 0.
- R7: A channel's flag is 1 exactly while its fill is strictly greater than the shared 2-bit watermark. It follows the fill in the same cycle, including dropping right after a pop.
- R8: A watermark of 2 or 3 keeps both flags at 0 even with full FIFOs.
- R9: A capture and a pop in the same cycle at a full FIFO are both accepted: the oldest word leaves, the new word enters, and no overflow is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | 16 | Running counter value to capture |
| sec_in | input | 1 | Asynchronous secondary input |
| mode_a | input | 2 | Edge selection, channel A |
| mode_b | input | 2 | Edge selection, channel B |
| water_mark | input | 2 | Shared fill watermark |
| pop_a | input | 1 | Pop strobe, channel A |
| pop_b | input | 1 | Pop strobe, channel B |
| data_a | output | 16 | Oldest word, channel A |
| data_b | output | 16 | Oldest word, channel B |
| fill_a | output | 2 | Word count, channel A |
| fill_b | output | 2 | Word count, channel B |
| flag_a | output | 1 | Capture flag, channel A |
| flag_b | output | 1 | Capture flag, channel B |
| ovf_a | output | 1 | Sticky overflow, channel A |
| ovf_b | output | 1 | Sticky overflow, channel B |

## Verification
The shared input is toggled with the channels in opposite edge selections (rising against falling), in both-edge against disabled, and with one channel disabled. These patterns show whether each channel decodes its own mode and whether both see the same source. Distinct counter values on successive transitions expose ordering and sampling mistakes. Runs at watermarks 0, 1, 2 and 3 separate a strict comparison from a non-strict one and confirm the flag drops in the same cycle. A pop timed to coincide with a capture at a full FIFO, a capture into a full FIFO and a pop on an empty FIFO distinguish accepting, dropping and ignoring.

// File: rtl/cap_pkg.sv
package cap_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_RISE = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;
endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cap_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= din;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= 1'b0;
         else        chain[i] <= chain[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~prev;
   assign fall = ~chain[STAGES-1] & prev;

   assert_edge_excl_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rise, fall}));
   assert_rise_single_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 2,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] fill,
   output logic          ovf
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("cap_fifo: DEPTH must be at least 1");
   end
   if (W < 1) begin : g_bad_width
      $error("cap_fifo: W must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic          full, do_pop, do_push;

   function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full    = (fill == CW'(DEPTH));
   assign do_pop  = pop && (fill != '0);
   assign do_push = push && (!full || do_pop);

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
         ovf    <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= ptr_next(wr_ptr);
         if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
         if (push && !do_push) ovf <= 1'b1;
      end
   end

   assign dout = mem[rd_ptr];

   assert_fill_bound_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CW'(DEPTH));
   assert_ovf_sticky_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   assert_full_drop_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (ovf && fill == CW'(DEPTH)));
   assert_empty_pop_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (fill == '0 && pop && !push) |=> (fill == '0));
   assert_swap_full_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && pop && !ovf) |=> (!ovf && fill == CW'(DEPTH)));
endmodule

// File: rtl/cap_channel.sv
module cap_channel
   import cap_pkg::*;
#(
   parameter int W     = 16,
   parameter int DEPTH = 2,
   parameter int WM_W  = 2,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  edge_mode_e      mode,
   input  logic            rise,
   input  logic            fall,
   input  logic [W-1:0]    cnt,
   input  logic [WM_W-1:0] wm,
   input  logic            pop,
   output logic [W-1:0]    dout,
   output logic [CW-1:0]   fill,
   output logic            flag,
   output logic            ovf
);
   logic hit;

   always_comb begin
      case (mode)
         EDGE_FALL: hit = fall;
         EDGE_RISE: hit = rise;
         EDGE_BOTH: hit = rise | fall;
         default:   hit = 1'b0;
      endcase
   end

   cap_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .push (hit),
      .din  (cnt),
      .pop  (pop),
      .dout (dout),
      .fill (fill),
      .ovf  (ovf)
   );

   assign flag = int'(fill) > int'(wm);

   assert_off_no_fill_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == EDGE_OFF) |=> (fill <= $past(fill)));
   assert_high_wm_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (int'(wm) >= DEPTH) |-> !flag);
   assert_flag_drop_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (flag && pop && !hit && $stable(wm) && int'(fill) == int'(wm) + 1) |=> !flag);
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture
   import cap_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int DEPTH   = 2,
   parameter int WM_W    = 2,
   parameter int SYNC_N  = 2,
   localparam int CW     = $clog2(DEPTH + 1),
   localparam int NCH    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             sec_in,
   input  logic [1:0]       mode_a,
   input  logic [1:0]       mode_b,
   input  logic [WM_W-1:0]  water_mark,
   input  logic             pop_a,
   input  logic             pop_b,
   output logic [CNT_W-1:0] data_a,
   output logic [CNT_W-1:0] data_b,
   output logic [CW-1:0]    fill_a,
   output logic [CW-1:0]    fill_b,
   output logic             flag_a,
   output logic             flag_b,
   output logic             ovf_a,
   output logic             ovf_b
);
   logic rise, fall;

   logic [1:0]       mode_v [NCH];
   logic             pop_v  [NCH];
   logic [CNT_W-1:0] data_v [NCH];
   logic [CW-1:0]    fill_v [NCH];
   logic             flag_v [NCH];
   logic             ovf_v  [NCH];

   assign mode_v[0] = mode_a;
   assign mode_v[1] = mode_b;
   assign pop_v[0]  = pop_a;
   assign pop_v[1]  = pop_b;

   cap_sync_edge #(.STAGES(SYNC_N)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sec_in),
      .rise (rise),
      .fall (fall)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      cap_channel #(.W(CNT_W), .DEPTH(DEPTH), .WM_W(WM_W)) u_ch (
         .clk  (clk),
         .rst_n(rst_n),
         .mode (edge_mode_e'(mode_v[c])),
         .rise (rise),
         .fall (fall),
         .cnt  (cnt_val),
         .wm   (water_mark),
         .pop  (pop_v[c]),
         .dout (data_v[c]),
         .fill (fill_v[c]),
         .flag (flag_v[c]),
         .ovf  (ovf_v[c])
      );
   end

   assign data_a = data_v[0];
   assign data_b = data_v[1];
   assign fill_a = fill_v[0];
   assign fill_b = fill_v[1];
   assign flag_a = flag_v[0];
   assign flag_b = flag_v[1];
   assign ovf_a  = ovf_v[0];
   assign ovf_b  = ovf_v[1];

   assert_shared_src_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_a == mode_b && fill_a == fill_b && !pop_a && !pop_b && ovf_a == ovf_b)
      |=> (fill_a == fill_b));
endmodule

// File: tb/tb_dual_edge_capture.sv
`timescale 1ns/1ps
module tb_dual_edge_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt_val = '0;
   logic        sec_in = 1'b0;
   logic [1:0]  mode_a = 2'b00, mode_b = 2'b00;
   logic [1:0]  water_mark = 2'd0;
   logic        pop_a = 1'b0, pop_b = 1'b0;
   logic [15:0] data_a, data_b;
   logic [1:0]  fill_a, fill_b;
   logic        flag_a, flag_b, ovf_a, ovf_b;

   int n_run = 0, n_fail = 0;
   bit done = 0;
   logic [15:0] q_a[$], q_b[$];
   bit exp_ovf_a = 0, exp_ovf_b = 0;

   always #2 clk = ~clk;

   dual_edge_capture dut (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .sec_in(sec_in),
      .mode_a(mode_a), .mode_b(mode_b), .water_mark(water_mark),
      .pop_a(pop_a), .pop_b(pop_b), .data_a(data_a), .data_b(data_b),
      .fill_a(fill_a), .fill_b(fill_b), .flag_a(flag_a), .flag_b(flag_b),
      .ovf_a(ovf_a), .ovf_b(ovf_b));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit hits(input logic [1:0] m, input bit from, input bit to);
      if (from == to) return 0;
      case (m)
         2'b01: return from && !to;
         2'b10: return !from && to;
         2'b11: return 1;
         default: return 0;
      endcase
   endfunction

   task automatic check_state(input string req);
      chk(req, "fill_a", fill_a, q_a.size());
      chk(req, "fill_b", fill_b, q_b.size());
      chk(req, "flag_a", flag_a, int'(q_a.size() > water_mark));
      chk(req, "flag_b", flag_b, int'(q_b.size() > water_mark));
      chk(req, "ovf_a", ovf_a, exp_ovf_a);
      chk(req, "ovf_b", ovf_b, exp_ovf_b);
   endtask

   // driver: applies a level and pushes expected words into the scoreboard
   task automatic drive(input bit v, input logic [15:0] c, input string req);
      @(negedge clk);
      cnt_val = c;
      if (hits(mode_a, sec_in, v)) begin
         if (q_a.size() < 2) q_a.push_back(c); else exp_ovf_a = 1;
      end
      if (hits(mode_b, sec_in, v)) begin
         if (q_b.size() < 2) q_b.push_back(c); else exp_ovf_b = 1;
      end
      sec_in = v;
      repeat (4) @(negedge clk);
      check_state(req);
   endtask

   // monitor: pops the design and compares against the scoreboard front
   task automatic pop_ch(input bit ch_b, input string req);
      @(negedge clk);
      if (!ch_b) begin
         if (q_a.size() > 0) chk(req, "data_a", data_a, q_a[0]);
         pop_a = 1;
      end else begin
         if (q_b.size() > 0) chk(req, "data_b", data_b, q_b[0]);
         pop_b = 1;
      end
      @(negedge clk);
      pop_a = 0; pop_b = 0;
      if (!ch_b) begin if (q_a.size() > 0) void'(q_a.pop_front()); end
      else begin if (q_b.size() > 0) void'(q_b.pop_front()); end
      check_state(req);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check_state("R1");

      // R2/R3: opposite edge selections on the same input
      mode_a = 2'b10; mode_b = 2'b01; water_mark = 2'd0;
      drive(1, 16'h0011, "R2");
      drive(0, 16'h0022, "R2");
      chk("R7", "flag_a one word wm0", flag_a, 1);
      pop_ch(0, "R3");
      pop_ch(1, "R3");
      pop_ch(0, "R6");

      // R4/R7: both-edge vs disabled, ordering and flag drop
      mode_a = 2'b11; mode_b = 2'b00;
      drive(1, 16'h0033, "R2");
      drive(0, 16'h0044, "R4");
      water_mark = 2'd1;
      @(negedge clk);
      check_state("R7");
      pop_ch(0, "R4");
      chk("R7", "flag_a after pop", flag_a, 0);
      pop_ch(0, "R4");

      // R8: watermark at or above depth
      water_mark = 2'd2;
      drive(1, 16'h0055, "R8");
      drive(0, 16'h0066, "R8");
      chk("R8", "flag_a full wm2", flag_a, 0);
      water_mark = 2'd3;
      @(negedge clk);
      chk("R8", "flag_a full wm3", flag_a, 0);

      // R9: capture and pop in the same cycle at a full FIFO
      water_mark = 2'd0;
      @(negedge clk);
      cnt_val = 16'h0077;
      sec_in = 1;
      @(negedge clk);
      @(negedge clk);
      chk("R9", "data_a before swap", data_a, q_a[0]);
      pop_a = 1;
      @(negedge clk);
      pop_a = 0;
      void'(q_a.pop_front());
      q_a.push_back(16'h0077);
      @(negedge clk);
      check_state("R9");
      pop_ch(0, "R9");
      pop_ch(0, "R9");

      // R5: overflow drop and stickiness
      drive(0, 16'h0088, "R5");
      drive(1, 16'h0099, "R5");
      drive(0, 16'h00AA, "R5");
      pop_ch(0, "R5");
      pop_ch(0, "R5");
      chk("R5", "ovf_a sticky", ovf_a, 1);

      // R2: channel B alone rising, A falling
      mode_a = 2'b01; mode_b = 2'b10;
      drive(1, 16'h00BB, "R2");
      pop_ch(1, "R2");

      done = 1;
      finish_run();
   end
endmodule